// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is an SMBus target that holds a small bank of 8-bit configuration registers for a clock-generator style device. A host reaches them through indexed block transfers. A write carries a start index, a byte count and the data. A read first sets the index with a short write, then issues a repeated start with the read address. The target answers with a byte count and then returns register contents until the host declines a byte.

SCL and SDA are first passed through a synchronizer and a majority-free glitch filter that runs on the system clock. A bit-level engine then detects start and stop, shifts bytes, matches the address and drives the open-drain SDA through an output enable. Its index advances after every data byte. The register bank latches the strap pins while reset is held. It applies per-bit write masks and presents every register on a flat parallel bus, so the rest of the chip sees the configuration without any extra access logic.

Top module: `smb_cfg_target`

## Requirements
- R1: While reset is held, control register 0 loads bits 7:4 from `strap_fsel_i` and bit 3 from `strap_spread_i`, with bits 2:0 cleared. Register 1 resets to 0xFF, register 2 to 0x00, register 4 to 0x01, register 5 to 0x08 and register 8 to 0x07. Register i appears on `cfg_o[8*i+7:8*i]`.
- R2: Only the address bytes 0xDC (write) and 0xDD (read) are acknowledged. Any other address is not acknowledged, and the target ignores the rest of that transfer until the next start.
- R3: A write is start, 0xDC, index N, count X, then data. Each of these bytes is acknowledged, and data byte k goes to register N+k.
- R4: Once X data bytes have been taken, further data bytes in the same write are not acknowledged and are not stored.
- R5: A read is start, 0xDC, index N, repeated start, 0xDD. The target then sends the value of register 8 first, followed by registers N, N+1 and so on. It continues while the host acknowledges and stops driving after a host NACK.
- R6: Register 8 is fully writable, and its value is the first byte of every following read.
- R7: Register 0 bits 2:0 are always writable. Bits 7:3 change on a write only when register 0 bit 2 was already 1 before that write.
- R8: Register 3 reads the live straps as {fsel[3:0], spread, 3'b000}, whatever the software-select bit holds.
- R9: Writes to read-only registers (3, 4, 6, 7) and to indices 9 and above are acknowledged but have no effect. In registers 1 and 2 only bits 6, 5, 2 and 1 take written values. Indices 9 and above read as 0x00.
- R10: `sda_oe_o` changes only while the filtered SCL is low, and it is 0 after a stop. `sda_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and state |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_o | output | 1 | SDA output value, constant 0 (open drain) |
| sda_oe_o | output | 1 | SDA pull-down enable |
| strap_fsel_i | input | 4 | Frequency-select strap pins |
| strap_spread_i | input | 1 | Spread-enable strap pin |
| cfg_o | output | 8*NREG | Parallel view of all registers, register 0 in the low byte |

## Verification
The assertions assume a well-formed host. SDA changes only while SCL is low, except at deliberate start and stop conditions. Each SCL phase lasts longer than the synchronizer plus filter latency. The straps are held steady during reset. The bench master keeps every quarter bit period at twelve system clocks, releases SDA whenever the target may drive it, and changes the straps only while the bus is idle.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACKTX,
        PH_TX,
        PH_ACKRX,
        PH_WAIT
    } phase_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_IDX,
        RL_CNT,
        RL_DATA
    } role_e;

    localparam int unsigned CTRL_IDX  = 0;
    localparam int unsigned LIVE_IDX  = 3;
    localparam int unsigned BCNT_IDX  = 8;
    localparam int unsigned SWSEL_BIT = 2;
    localparam logic [7:0]  VEND_REV  = 8'h01;

    // reset value of every register except the strap-loaded control byte
    function automatic logic [7:0] reg_reset(int unsigned i);
        case (i)
            1:       return 8'hFF;
            4:       return VEND_REV;
            5:       return 8'h08;
            8:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    // bits that take written data; control byte depends on software select
    function automatic logic [7:0] reg_wmask(int unsigned i, logic sw);
        case (i)
            0:       return sw ? 8'hFF : 8'h07;
            1, 2:    return 8'h66;
            5, 8:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
`timescale 1ns/1ps
module smb_glitch_filter #(
    parameter int SYNC = 2,
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic [FILT-1:0] hist;
        logic            q;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], d_i};
        st_d.hist = {st_q.hist[FILT-2:0], st_q.sync[SYNC-1]};
        if (&st_q.hist) begin
            st_d.q = 1'b1;
        end else if (~|st_q.hist) begin
            st_d.q = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

endmodule

// File: rtl/smb_bus_engine.sv
`timescale 1ns/1ps
module smb_bus_engine
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h6E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [7:0] bcount_i,
    input  logic [7:0] rdata_i,
    output logic [7:0] rd_idx_o,
    output logic       wr_en_o,
    output logic [7:0] wr_idx_o,
    output logic [7:0] wr_data_o,
    output logic       sda_oe_o
);

    typedef struct packed {
        phase_e     ph;
        role_e      role;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] idx;
        logic [7:0] remain;
        logic       acked;
        logic       rd_mode;
        logic       oe;
        logic       wr;
        logic [7:0] widx;
        logic [7:0] wdata;
        logic       scl_p;
        logic       sda_p;
    } eng_t;

    eng_t st_d, st_q;

    logic scl_rise, scl_fall, bus_start, bus_stop;

    always_comb begin
        scl_rise  = scl_i & ~st_q.scl_p;
        scl_fall  = ~scl_i & st_q.scl_p;
        bus_start = scl_i & st_q.scl_p & st_q.sda_p & ~sda_i;
        bus_stop  = scl_i & st_q.scl_p & ~st_q.sda_p & sda_i;

        st_d       = st_q;
        st_d.wr    = 1'b0;
        st_d.scl_p = scl_i;
        st_d.sda_p = sda_i;

        if (bus_start) begin
            st_d.ph   = PH_RX;
            st_d.role = RL_ADDR;
            st_d.cnt  = 4'd0;
            st_d.oe   = 1'b0;
        end else if (bus_stop) begin
            st_d.ph = PH_IDLE;
            st_d.oe = 1'b0;
        end else begin
            case (st_q.ph)
                PH_RX: begin
                    if (scl_rise && st_q.cnt < 4'd8) begin
                        st_d.sh  = {st_q.sh[6:0], sda_i};
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall && st_q.cnt == 4'd8) begin
                        st_d.cnt   = 4'd0;
                        st_d.acked = 1'b1;
                        case (st_q.role)
                            RL_ADDR: begin
                                st_d.acked   = (st_q.sh[7:1] == ADDR7);
                                st_d.rd_mode = st_q.sh[0];
                            end
                            RL_IDX:  st_d.idx    = st_q.sh;
                            RL_CNT:  st_d.remain = st_q.sh;
                            default: begin
                                if (st_q.remain != 8'd0) begin
                                    st_d.wr     = 1'b1;
                                    st_d.widx   = st_q.idx;
                                    st_d.wdata  = st_q.sh;
                                    st_d.idx    = st_q.idx + 8'd1;
                                    st_d.remain = st_q.remain - 8'd1;
                                end else begin
                                    st_d.acked = 1'b0;
                                end
                            end
                        endcase
                        st_d.ph = st_d.acked ? PH_ACKTX : PH_WAIT;
                        st_d.oe = st_d.acked;
                    end
                end
                PH_ACKTX: begin
                    if (scl_fall) begin
                        st_d.oe  = 1'b0;
                        st_d.cnt = 4'd0;
                        if (st_q.role == RL_ADDR && st_q.rd_mode) begin
                            st_d.ph = PH_TX;
                            st_d.sh = bcount_i;
                            st_d.oe = ~bcount_i[7];
                        end else begin
                            st_d.ph = PH_RX;
                            case (st_q.role)
                                RL_ADDR: st_d.role = RL_IDX;
                                RL_IDX:  st_d.role = RL_CNT;
                                default: st_d.role = RL_DATA;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (st_q.cnt == 4'd7) begin
                            st_d.ph  = PH_ACKRX;
                            st_d.oe  = 1'b0;
                            st_d.cnt = 4'd0;
                        end else begin
                            st_d.sh  = {st_q.sh[6:0], 1'b0};
                            st_d.cnt = st_q.cnt + 4'd1;
                            st_d.oe  = ~st_q.sh[6];
                        end
                    end
                end
                PH_ACKRX: begin
                    if (scl_rise) begin
                        st_d.acked = ~sda_i;
                    end else if (scl_fall) begin
                        if (st_q.acked) begin
                            st_d.ph  = PH_TX;
                            st_d.sh  = rdata_i;
                            st_d.oe  = ~rdata_i[7];
                            st_d.idx = st_q.idx + 8'd1;
                            st_d.cnt = 4'd0;
                        end else begin
                            st_d.ph = PH_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ph    <= PH_IDLE;
            st_q.role  <= RL_ADDR;
            st_q.scl_p <= 1'b1;
            st_q.sda_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx_o  = st_q.idx;
    assign wr_en_o   = st_q.wr;
    assign wr_idx_o  = st_q.widx;
    assign wr_data_o = st_q.wdata;
    assign sda_oe_o  = st_q.oe;

endmodule

// File: rtl/smb_cfg_bank.sv
`timescale 1ns/1ps
module smb_cfg_bank
    import smb_cfg_pkg::*;
#(
    parameter int NREG = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      strap_fsel_i,
    input  logic            strap_spread_i,
    input  logic            wr_en_i,
    input  logic [7:0]      wr_idx_i,
    input  logic [7:0]      wr_data_i,
    input  logic [7:0]      rd_idx_i,
    output logic [7:0]      rd_data_o,
    output logic [7:0]      bcount_o,
    output logic [NREG*8-1:0] regs_o
);

    logic [7:0] bank_d [NREG];
    logic [7:0] bank_q [NREG];
    logic [7:0] view   [NREG];
    logic [7:0] strap_byte;

    assign strap_byte = {strap_fsel_i, strap_spread_i, 3'b000};

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_idx_i == 8'(i)) begin
                    bank_d[i] = (bank_q[i] & ~reg_wmask(i, bank_q[CTRL_IDX][SWSEL_BIT]))
                              | (wr_data_i & reg_wmask(i, bank_q[CTRL_IDX][SWSEL_BIT]));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                bank_q[i] <= (i == CTRL_IDX) ? strap_byte : reg_reset(i);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_view
        if (g == LIVE_IDX) begin : g_live
            assign view[g] = strap_byte | bank_q[g];
        end else begin : g_store
            assign view[g] = bank_q[g];
        end
        assign regs_o[g*8 +: 8] = view[g];
    end

    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx_i == 8'(i)) begin
                rd_data_o = view[i];
            end
        end
    end

    assign bcount_o = bank_q[BCNT_IDX];

endmodule

// File: rtl/smb_cfg_target.sv
`timescale 1ns/1ps
module smb_cfg_target #(
    parameter int         NREG        = 9,
    parameter logic [6:0] TARGET_ADDR = 7'h6E,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe_o,
    input  logic [3:0]        strap_fsel_i,
    input  logic              strap_spread_i,
    output logic [NREG*8-1:0] cfg_o
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic wr_en;
    logic [7:0] wr_idx, wr_data, rd_idx, rd_data, bcount;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        smb_glitch_filter #(.SYNC(SYNC_STAGES), .FILT(FILT_LEN)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_lines[g]),
            .q_o   (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    smb_bus_engine #(.ADDR7(TARGET_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_f),
        .sda_i     (sda_f),
        .bcount_i  (bcount),
        .rdata_i   (rd_data),
        .rd_idx_o  (rd_idx),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    smb_cfg_bank #(.NREG(NREG)) u_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_fsel_i   (strap_fsel_i),
        .strap_spread_i (strap_spread_i),
        .wr_en_i        (wr_en),
        .wr_idx_i       (wr_idx),
        .wr_data_i      (wr_data),
        .rd_idx_i       (rd_idx),
        .rd_data_o      (rd_data),
        .bcount_o       (bcount),
        .regs_o         (cfg_o)
    );

    assign sda_o = 1'b0;

endmodule

// File: rtl/smb_cfg_checker.sv
`timescale 1ns/1ps
module smb_cfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_f,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] ctrl,
    input logic [7:0] oe_bank
);

    a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    a_r10_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_f);

    a_r10_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(sda_f) && sda_f) |=> !sda_oe);

    a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

    a_r7_ctrl_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl[2]) |-> (ctrl[7:3] == $past(ctrl[7:3])));

    a_r9_reserved_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({oe_bank[7], oe_bank[4], oe_bank[3], oe_bank[0]}));

endmodule

bind smb_cfg_target smb_cfg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .sda_oe  (sda_oe_o),
    .wr_en   (wr_en),
    .ctrl    (cfg_o[7:0]),
    .oe_bank (cfg_o[15:8])
);

// File: tb/sim_smb_cfg_target.sv
`timescale 1ns/1ps
module sim_smb_cfg_target;

    localparam int NREG = 9;
    localparam int Q    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_o, sda_oe;
    logic sda_line;
    logic [3:0] strap_fsel = 4'hA;
    logic strap_spread = 1'b1;
    logic [NREG*8-1:0] cfg;

    assign sda_line = m_sda & (sda_oe ? sda_o : 1'b1);

    smb_cfg_target #(.NREG(NREG)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (m_scl),
        .sda_i          (sda_line),
        .sda_o          (sda_o),
        .sda_oe_o       (sda_oe),
        .strap_fsel_i   (strap_fsel),
        .strap_spread_i (strap_spread),
        .cfg_o          (cfg)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int cfg_byte(input int i);
        return int'(cfg[i*8 +: 8]);
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                int a;
                a = obs_q.pop_front();
                if (exp_q.size() == 0) check("scoreboard underflow", a, -1);
                else check(tag_q.pop_front(), a, exp_q.pop_front());
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input int exp_ack, input string tag);
        logic b;
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        obs_q.push_back(b ? 0 : 1);
    endtask

    task automatic rd_byte(input int exp_v, input logic last, input string tag);
        logic [7:0] v;
        logic b;
        exp_q.push_back(exp_v);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(last);
        obs_q.push_back(int'(v));
    endtask

    task automatic begin_write(input logic [7:0] idx, input logic [7:0] cnt);
        bus_start();
        wr_byte(8'hDC, 1, "R2 write address ack");
        wr_byte(idx, 1, "R3 index ack");
        wr_byte(cnt, 1, "R3 count ack");
    endtask

    task automatic begin_read(input logic [7:0] idx);
        bus_start();
        wr_byte(8'hDC, 1, "R5 setup address ack");
        wr_byte(idx, 1, "R5 setup index ack");
        bus_start();
        wr_byte(8'hDD, 1, "R5 read address ack");
    endtask

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(10);

        // R1 reset values, R8 live readback
        check("R1 ctrl from straps", cfg_byte(0), 'hA8);
        check("R1 output enable reset", cfg_byte(1), 'hFF);
        check("R1 stop enable reset", cfg_byte(2), 'h00);
        check("R8 strap readback", cfg_byte(3), 'hA8);
        check("R1 vendor byte", cfg_byte(4), 'h01);
        check("R1 device id", cfg_byte(5), 'h08);
        check("R1 byte count reset", cfg_byte(8), 'h07);
        check("R10 idle release", int'(sda_oe), 0);

        // R2 foreign address
        bus_start();
        wr_byte(8'hA0, 0, "R2 foreign address nack");
        wr_byte(8'h05, 0, "R2 ignored byte");
        wr_byte(8'h01, 0, "R2 ignored byte");
        wr_byte(8'h99, 0, "R2 ignored byte");
        bus_stop();
        check("R2 no write after nack", cfg_byte(5), 'h08);

        // R3 writes with auto-increment, R9 masks
        begin_write(8'd5, 8'd1);
        wr_byte(8'h3C, 1, "R3 data ack");
        bus_stop();
        check("R3 single write", cfg_byte(5), 'h3C);
        begin_write(8'd1, 8'd2);
        wr_byte(8'h00, 1, "R3 data ack");
        wr_byte(8'hFF, 1, "R3 data ack");
        bus_stop();
        check("R9 reg1 masked", cfg_byte(1), 'h99);
        check("R3 increment R9 reg2 masked", cfg_byte(2), 'h66);

        // R4 past count
        begin_write(8'd1, 8'd1);
        wr_byte(8'hFF, 1, "R4 in-count ack");
        wr_byte(8'h00, 0, "R4 byte past count nack");
        bus_stop();
        check("R4 in-count written", cfg_byte(1), 'hFF);
        check("R4 past count not written", cfg_byte(2), 'h66);

        // R9 read-only register
        begin_write(8'd4, 8'd1);
        wr_byte(8'h00, 1, "R9 read-only ack");
        bus_stop();
        check("R9 read-only unchanged", cfg_byte(4), 'h01);

        // R7 control guard
        begin_write(8'd0, 8'd1);
        wr_byte(8'h07, 1, "R7 data ack");
        bus_stop();
        check("R7 low bits only", cfg_byte(0), 'hAF);
        begin_write(8'd0, 8'd1);
        wr_byte(8'h50, 1, "R7 data ack");
        bus_stop();
        check("R7 full write when selected", cfg_byte(0), 'h50);
        begin_write(8'd0, 8'd1);
        wr_byte(8'hFF, 1, "R7 data ack");
        bus_stop();
        check("R7 guard restored", cfg_byte(0), 'h57);

        // R8 live straps
        strap_fsel = 4'h5;
        strap_spread = 1'b0;
        tick(4);
        check("R8 live readback", cfg_byte(3), 'h50);
        check("R7 ctrl keeps value", cfg_byte(0), 'h57);

        // R5 read
        begin_read(8'd5);
        rd_byte('h07, 1'b0, "R5 count byte");
        rd_byte('h3C, 1'b0, "R5 data reg5");
        rd_byte('h00, 1'b0, "R5 data reg6");
        rd_byte('h00, 1'b1, "R5 data reg7");
        bus_stop();
        check("R10 released after read", int'(sda_oe), 0);

        // R6 count register
        begin_write(8'd8, 8'd1);
        wr_byte(8'h02, 1, "R6 data ack");
        bus_stop();
        check("R6 count written", cfg_byte(8), 'h02);
        begin_read(8'd0);
        rd_byte('h02, 1'b0, "R6 count byte");
        rd_byte('h57, 1'b0, "R5 reg0");
        rd_byte('hFF, 1'b0, "R5 reg1");
        rd_byte('h66, 1'b0, "R5 reg2");
        rd_byte('h50, 1'b1, "R8 reg3 over bus");
        bus_stop();

        // R9 out-of-range read
        begin_read(8'd9);
        rd_byte('h02, 1'b0, "R6 count byte");
        rd_byte('h00, 1'b1, "R9 out of range reads zero");
        bus_stop();
        check("R10 released at end", int'(sda_oe), 0);
        check("R10 line idle high", int'(sda_line), 1);

        tick(20);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule